// File: doc/BRIEF.md
# Branch and Jump Redirect Controller

This block picks the next fetch address for a five-stage in-order pipeline and tells the pipeline which younger instructions to discard. It assumes that branches fall through. An unconditional jump is acted on as soon as it reaches decode. A conditional branch (branch-if-equal or branch-if-not-equal) is acted on only in execute, where the ALU zero flag settles its outcome.

A jump replaces the one instruction fetched behind it with a bubble. A taken branch replaces the two instructions behind it with bubbles: the one in decode and the one being fetched. A branch that is not taken disturbs nothing.

The block owns the fetch PC register. It forms the branch target from the branch's own next-sequential address and its 16-bit word offset. It also keeps a small model of which decode and execute slots hold live work, so that control bits arriving from a slot it has already squashed are ignored. The slot model is a four-state machine:

- BOTH_DEAD: decode and execute both bubbles. This is the state after reset and after a taken branch.
- EX_DEAD: decode live, execute bubble.
- ID_DEAD: decode bubble, execute live. This is the state after a jump.
- RUN: both slots live.

The machine has these transitions:

- REDIRECT_BR: a taken branch moves any state to BOTH_DEAD.
- REDIRECT_J: an accepted jump moves any state with a live decode slot to ID_DEAD.
- ADVANCE: with no redirect, the liveness of decode moves into execute and decode becomes live. This gives BOTH_DEAD→EX_DEAD, ID_DEAD→EX_DEAD, EX_DEAD→RUN and RUN→RUN.

Top module: `brflush_ctrl`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `pc` equals RESET_PC (default 0x400), `id_live` and `ex_live` are 0, and every control input is ignored. On that first cycle `pc_sel` is 0 and both flush outputs are 0. On the second cycle `id_live` is 1 and `ex_live` is 0.
- R2: With no redirect, `pc_sel` is 0 (sequential) and `pc` advances by 4 on each clock edge.
- R3: A jump in a live decode slot, with no taken branch, drives `pc_sel`=1, `flush_if`=1 and `flush_id`=0 in the same cycle. On the next edge `pc` loads `jump_target`.
- R4: On the cycle after an accepted jump, `id_live`=0 and `ex_live`=1, and a jump request in that cycle is ignored. A slot that is dead in decode is always dead in execute one cycle later.
- R5: A branch in a live execute slot is taken when it is `ex_beq` with `ex_zero`=1, or `ex_bne` with `ex_zero`=0. It then drives `pc_sel`=2, `flush_if`=1 and `flush_id`=1, and `pc` loads `ex_npc` + 4 × sign-extended `ex_imm`.
- R6: A branch that is not taken (`ex_beq` with zero 0, or `ex_bne` with zero 1) gives `pc_sel`=0, no flush, and a sequential `pc`.
- R7: On the cycle after a taken branch, both slots are dead. On the cycle after that, `ex_live`=0 and `id_live`=1. Branch and jump requests from dead slots have no effect on `pc` or on the flush outputs.
- R8: When a taken branch in execute and a jump in decode occur in the same cycle, the branch wins: `pc_sel`=2 and `pc` loads the branch target.
- R9: A negative offset (top bit of `ex_imm` set) moves the branch target backwards. For example, offset 0xFFF8 from `ex_npc` 0x3000 gives 0x2FE0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| id_jump | input | 1 | Decode-stage instruction is a jump |
| jump_target | input | ADDR_W | Jump destination from decode |
| ex_beq | input | 1 | Execute-stage instruction is branch-if-equal |
| ex_bne | input | 1 | Execute-stage instruction is branch-if-not-equal |
| ex_zero | input | 1 | ALU zero flag for the execute-stage instruction |
| ex_npc | input | ADDR_W | Next-sequential address (PC+4) of the execute-stage instruction |
| ex_imm | input | IMM_W | Branch word offset, signed |
| pc | output | ADDR_W | Current fetch address |
| pc_sel | output | 2 | Next-PC choice: 0 sequential, 1 jump, 2 branch |
| flush_if | output | 1 | Load a bubble into the instruction register at the next edge |
| flush_id | output | 1 | Load a bubble into the decode-to-execute control bundle at the next edge |
| id_live | output | 1 | Decode slot holds a live instruction |
| ex_live | output | 1 | Execute slot holds a live instruction |

## Verification
The bound checker watches, on every cycle, the flush pattern tied to each redirect kind, the sequential PC step, the PC load from the computed branch target, the slot liveness that follows a jump or a taken branch, and the rule that a dead decode slot becomes a dead execute slot. Only the bench's scenarios can show the following:

- The branch decision for each combination of branch type and zero flag.
- That requests arriving from squashed slots are really ignored.
- The priority between a branch and a jump in the same cycle.
- Exact target values, including backward offsets.
- The behaviour in the first cycles after reset.

// File: rtl/brflush_pkg.sv
package brflush_pkg;

    typedef enum logic [1:0] {
        SEL_SEQ    = 2'd0,
        SEL_JUMP   = 2'd1,
        SEL_BRANCH = 2'd2
    } npc_sel_e;

    typedef enum logic [1:0] {
        ST_BOTH_DEAD = 2'd0,
        ST_EX_DEAD   = 2'd1,
        ST_ID_DEAD   = 2'd2,
        ST_RUN       = 2'd3
    } slot_state_e;

endpackage

// File: rtl/brflush_target.sv
module brflush_target #(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [ADDR_W-1:0] npc,
    input  logic [IMM_W-1:0]  imm,
    output logic [ADDR_W-1:0] target
);
    localparam int EXT_W = ADDR_W - IMM_W;

    logic [ADDR_W-1:0] imm_sext;
    logic [ADDR_W-1:0] byte_ofs;

    generate
        if (EXT_W > 0) begin : g_ext
            assign imm_sext = {{EXT_W{imm[IMM_W-1]}}, imm};
        end else begin : g_trunc
            assign imm_sext = imm[ADDR_W-1:0];
        end
    endgenerate

    // word offset to byte offset
    assign byte_ofs = {imm_sext[ADDR_W-3:0], 2'b00};
    assign target   = npc + byte_ofs;

endmodule

// File: rtl/brflush_decide.sv
module brflush_decide
    import brflush_pkg::*;
(
    input  logic     id_live,
    input  logic     ex_live,
    input  logic     id_jump,
    input  logic     ex_beq,
    input  logic     ex_bne,
    input  logic     ex_zero,
    output logic     br_take,
    output logic     jmp_take,
    output npc_sel_e sel,
    output logic     flush_if,
    output logic     flush_id
);
    logic cond_met;

    always_comb begin
        cond_met = (ex_beq && ex_zero) || (ex_bne && !ex_zero);
        br_take  = ex_live && cond_met;
        // the jump sits on the squashed path when a branch redirects
        jmp_take = id_live && id_jump && !br_take;
    end

    always_comb begin
        if (br_take) begin
            sel      = SEL_BRANCH;
            flush_if = 1'b1;
            flush_id = 1'b1;
        end else if (jmp_take) begin
            sel      = SEL_JUMP;
            flush_if = 1'b1;
            flush_id = 1'b0;
        end else begin
            sel      = SEL_SEQ;
            flush_if = 1'b0;
            flush_id = 1'b0;
        end
    end

endmodule

// File: rtl/brflush_slot_fsm.sv
module brflush_slot_fsm
    import brflush_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic br_take,
    input  logic jmp_take,
    output logic id_live,
    output logic ex_live
);
    slot_state_e state_q;
    slot_state_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_BOTH_DEAD;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: REDIRECT_BR, REDIRECT_J, ADVANCE
    always_comb begin
        state_d = state_q;
        if (br_take) begin
            state_d = ST_BOTH_DEAD;
        end else if (jmp_take) begin
            state_d = ST_ID_DEAD;
        end else begin
            unique case (state_q)
                ST_BOTH_DEAD: state_d = ST_EX_DEAD;
                ST_ID_DEAD:   state_d = ST_EX_DEAD;
                ST_EX_DEAD:   state_d = ST_RUN;
                ST_RUN:       state_d = ST_RUN;
                default:      state_d = ST_BOTH_DEAD;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_BOTH_DEAD: begin id_live = 1'b0; ex_live = 1'b0; end
            ST_EX_DEAD:   begin id_live = 1'b1; ex_live = 1'b0; end
            ST_ID_DEAD:   begin id_live = 1'b0; ex_live = 1'b1; end
            ST_RUN:       begin id_live = 1'b1; ex_live = 1'b1; end
            default:      begin id_live = 1'b0; ex_live = 1'b0; end
        endcase
    end

endmodule

// File: rtl/brflush_pc_reg.sv
module brflush_pc_reg
    import brflush_pkg::*;
#(
    parameter int              ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] RESET_PC = 32'h0000_0400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  npc_sel_e          sel,
    input  logic [ADDR_W-1:0] jump_target,
    input  logic [ADDR_W-1:0] br_target,
    output logic [ADDR_W-1:0] pc
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

    logic [ADDR_W-1:0] pc_q;
    logic [ADDR_W-1:0] pc_d;

    always_comb begin
        unique case (sel)
            SEL_JUMP:   pc_d = jump_target;
            SEL_BRANCH: pc_d = br_target;
            SEL_SEQ:    pc_d = pc_q + STEP;
            default:    pc_d = pc_q + STEP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= RESET_PC;
        end else begin
            pc_q <= pc_d;
        end
    end

    assign pc = pc_q;

endmodule

// File: rtl/brflush_ctrl.sv
module brflush_ctrl
    import brflush_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter int                IMM_W    = 16,
    parameter logic [ADDR_W-1:0] RESET_PC = 32'h0000_0400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              id_jump,
    input  logic [ADDR_W-1:0] jump_target,
    input  logic              ex_beq,
    input  logic              ex_bne,
    input  logic              ex_zero,
    input  logic [ADDR_W-1:0] ex_npc,
    input  logic [IMM_W-1:0]  ex_imm,
    output logic [ADDR_W-1:0] pc,
    output logic [1:0]        pc_sel,
    output logic              flush_if,
    output logic              flush_id,
    output logic              id_live,
    output logic              ex_live
);
    logic              br_take;
    logic              jmp_take;
    npc_sel_e          sel;
    logic [ADDR_W-1:0] br_target;

    brflush_target #(
        .ADDR_W (ADDR_W),
        .IMM_W  (IMM_W)
    ) u_target (
        .npc    (ex_npc),
        .imm    (ex_imm),
        .target (br_target)
    );

    brflush_decide u_decide (
        .id_live  (id_live),
        .ex_live  (ex_live),
        .id_jump  (id_jump),
        .ex_beq   (ex_beq),
        .ex_bne   (ex_bne),
        .ex_zero  (ex_zero),
        .br_take  (br_take),
        .jmp_take (jmp_take),
        .sel      (sel),
        .flush_if (flush_if),
        .flush_id (flush_id)
    );

    brflush_slot_fsm u_slots (
        .clk      (clk),
        .rst_n    (rst_n),
        .br_take  (br_take),
        .jmp_take (jmp_take),
        .id_live  (id_live),
        .ex_live  (ex_live)
    );

    brflush_pc_reg #(
        .ADDR_W   (ADDR_W),
        .RESET_PC (RESET_PC)
    ) u_pc (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel         (sel),
        .jump_target (jump_target),
        .br_target   (br_target),
        .pc          (pc)
    );

    assign pc_sel = sel;

endmodule

// File: rtl/brflush_ctrl_chk.sv
module brflush_ctrl_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] pc,
    input logic [1:0]        pc_sel,
    input logic              flush_if,
    input logic              flush_id,
    input logic              id_live,
    input logic              ex_live,
    input logic [ADDR_W-1:0] br_target
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

    p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_sel == 2'd0) |=> (pc == $past(pc) + STEP));

    p_seq_no_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_sel == 2'd0) |-> (!flush_if && !flush_id));

    p_jump_flush_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_sel == 2'd1) |-> (flush_if && !flush_id));

    p_jump_slots_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_sel == 2'd1) |=> (!id_live && ex_live));

    p_dead_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!id_live) |=> (!ex_live));

    p_branch_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_sel == 2'd2) |-> (flush_if && flush_id));

    p_branch_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_sel == 2'd2) |=> (pc == $past(br_target)));

    p_branch_slots_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_sel == 2'd2) |=> (!id_live && !ex_live));

    p_dead_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!id_live && !ex_live) |-> (pc_sel == 2'd0));

    p_sel_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_sel != 2'd3));

endmodule

bind brflush_ctrl brflush_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pc        (pc),
    .pc_sel    (pc_sel),
    .flush_if  (flush_if),
    .flush_id  (flush_id),
    .id_live   (id_live),
    .ex_live   (ex_live),
    .br_target (br_target)
);

// File: tb/brflush_ctrl_tb.sv
module brflush_ctrl_tb;
    localparam int AW = 32;
    localparam int IW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          id_jump = 1'b0;
    logic [AW-1:0] jump_target = '0;
    logic          ex_beq = 1'b0;
    logic          ex_bne = 1'b0;
    logic          ex_zero = 1'b0;
    logic [AW-1:0] ex_npc = '0;
    logic [IW-1:0] ex_imm = '0;
    logic [AW-1:0] pc;
    logic [1:0]    pc_sel;
    logic          flush_if, flush_id, id_live, ex_live;

    int n_chk = 0;
    int n_bad = 0;
    logic [AW-1:0] exp_pc;

    always #4 clk = ~clk;   // 125 MHz

    brflush_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .id_jump(id_jump), .jump_target(jump_target),
        .ex_beq(ex_beq), .ex_bne(ex_bne), .ex_zero(ex_zero), .ex_npc(ex_npc),
        .ex_imm(ex_imm), .pc(pc), .pc_sel(pc_sel), .flush_if(flush_if),
        .flush_id(flush_id), .id_live(id_live), .ex_live(ex_live)
    );

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic j, input logic [AW-1:0] jt, input logic qb,
                         input logic nb, input logic z, input logic [AW-1:0] npc,
                         input logic [IW-1:0] imm);
        id_jump = j; jump_target = jt; ex_beq = qb; ex_bne = nb;
        ex_zero = z; ex_npc = npc; ex_imm = imm;
        #1;
    endtask

    task automatic idle();
        drive(1'b0, '0, 1'b0, 1'b0, 1'b0, '0, '0);
    endtask

    task automatic comb(input string req, input logic [1:0] s, input logic fi, input logic fd);
        chk({req, " pc_sel"}, AW'(pc_sel), AW'(s));
        chk({req, " flush_if"}, AW'(flush_if), AW'(fi));
        chk({req, " flush_id"}, AW'(flush_id), AW'(fd));
    endtask

    task automatic tick(input string req, input logic [AW-1:0] npc_exp,
                        input logic il, input logic el);
        @(negedge clk);
        exp_pc = npc_exp;
        chk({req, " pc"}, pc, exp_pc);
        chk({req, " id_live"}, AW'(id_live), AW'(il));
        chk({req, " ex_live"}, AW'(ex_live), AW'(el));
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1 pc in reset", pc, 32'h400);
        chk("R1 id_live in reset", AW'(id_live), '0);
        rst_n = 1'b1;
        drive(1'b1, 32'h9000, 1'b1, 1'b0, 1'b1, 32'h100, 16'h1);
        comb("R1 first cycle ignored", 2'd0, 1'b0, 1'b0);
        tick("R1", 32'h404, 1'b1, 1'b0);
    endtask

    task automatic t_seq();
        idle();
        comb("R2", 2'd0, 1'b0, 1'b0);
        tick("R2", 32'h408, 1'b1, 1'b1);
        idle();
        tick("R2", 32'h40C, 1'b1, 1'b1);
    endtask

    task automatic t_jump();
        drive(1'b1, 32'h2000, 1'b0, 1'b0, 1'b0, '0, '0);
        comb("R3", 2'd1, 1'b1, 1'b0);
        tick("R3/R4", 32'h2000, 1'b0, 1'b1);
        drive(1'b1, 32'h3000, 1'b0, 1'b0, 1'b0, '0, '0);
        comb("R4 dead jump", 2'd0, 1'b0, 1'b0);
        tick("R4", 32'h2004, 1'b1, 1'b0);
        drive(1'b0, '0, 1'b1, 1'b0, 1'b1, 32'h50, 16'h4);
        comb("R4 dead ex", 2'd0, 1'b0, 1'b0);
        tick("R4", 32'h2008, 1'b1, 1'b1);
    endtask

    task automatic t_beq_taken();
        drive(1'b0, '0, 1'b1, 1'b0, 1'b1, 32'h2100, 16'h0010);
        comb("R5 beq", 2'd2, 1'b1, 1'b1);
        tick("R5 beq", 32'h2140, 1'b0, 1'b0);
        drive(1'b1, 32'h7000, 1'b0, 1'b1, 1'b0, 32'h80, 16'h8);
        comb("R7 both dead", 2'd0, 1'b0, 1'b0);
        tick("R7", 32'h2144, 1'b1, 1'b0);
        drive(1'b0, '0, 1'b1, 1'b0, 1'b1, 32'h80, 16'h8);
        comb("R7 ex dead", 2'd0, 1'b0, 1'b0);
        tick("R7", 32'h2148, 1'b1, 1'b1);
    endtask

    task automatic t_not_taken();
        drive(1'b0, '0, 1'b1, 1'b0, 1'b0, 32'h500, 16'h10);
        comb("R6 beq nz", 2'd0, 1'b0, 1'b0);
        tick("R6", 32'h214C, 1'b1, 1'b1);
        drive(1'b0, '0, 1'b0, 1'b1, 1'b1, 32'h500, 16'h10);
        comb("R6 bne z", 2'd0, 1'b0, 1'b0);
        tick("R6", 32'h2150, 1'b1, 1'b1);
    endtask

    task automatic t_bne_back();
        drive(1'b0, '0, 1'b0, 1'b1, 1'b0, 32'h3000, 16'hFFF8);
        comb("R5 bne", 2'd2, 1'b1, 1'b1);
        tick("R9 backward", 32'h2FE0, 1'b0, 1'b0);
        idle();
        tick("R7", 32'h2FE4, 1'b1, 1'b0);
        idle();
        tick("R2", 32'h2FE8, 1'b1, 1'b1);
    endtask

    task automatic t_priority();
        drive(1'b1, 32'h5000, 1'b1, 1'b0, 1'b1, 32'h4000, 16'h0001);
        comb("R8", 2'd2, 1'b1, 1'b1);
        tick("R8", 32'h4004, 1'b0, 1'b0);
        idle();
        tick("R7", 32'h4008, 1'b1, 1'b0);
        drive(1'b1, 32'h6000, 1'b0, 1'b0, 1'b0, '0, '0);
        comb("R3 from ex-dead", 2'd1, 1'b1, 1'b0);
        tick("R3", 32'h6000, 1'b0, 1'b1);
        idle();
        tick("R4", 32'h6004, 1'b1, 1'b0);
    endtask

    logic done = 1'b0;

    initial begin
        t_reset();
        t_seq();
        t_jump();
        t_beq_taken();
        t_not_taken();
        t_bne_back();
        t_priority();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule